// File: doc/BRIEF.md
# Bus-Latched 10-bit Event Counter

This block counts rising edges of an asynchronous external input with a 10-bit up-counter. The input passes through a two-flop synchronizer, and a registered copy of its previous value detects each rising edge, so a level held high for many cycles counts only once. The counter wraps from all ones to zero. On that wrap it sets an interrupt request flag, which stays set until software clears it.

Software reaches the counter over an 8-bit register bus that has synchronous read and write strobes. Two byte accesses have to behave as one 10-bit access, so both directions use latches, and the order of the accesses matters:

- **Writing:** software writes the upper two bits first, which only loads a holding latch. It then writes the low byte, which loads all ten bits into the counter in one cycle.
- **Reading:** software reads the low byte first, which captures the upper two bits at the same instant. It then reads the upper register, which returns those captured bits.

A third register exposes the flag and lets software clear it.

Top module: `evcnt_top`

## Requirements
- R1: After reset, the low count register (address 0xA3), the high count register (address 0xA4) and the status register (address 0xA5) all read 0x00, and irq_o is 0.
- R2: Each rising edge of evt_i advances the counter by exactly one. The new value is in the counter on the third rising clock edge after evt_i rises. A level held high and a falling edge never advance it.
- R3: A write to 0xA4 only loads bits 1:0 of the data into a holding latch, and the counter is unchanged. A write to 0xA3 loads {holding latch, data} into the counter in that clock cycle.
- R4: A read of 0xA3 returns count bits 7:0 and captures count bits 9:8 at the same time. A later read of 0xA4 returns the captured bits, even if the counter has advanced in between.
- R5: A read of 0xA4 returns 0 in bits 7:2.
- R6: A counted edge that takes the counter from 0x3FF to 0x000 sets the overflow flag. The flag appears on irq_o and as bit 0 of the 0xA5 read data. It stays set while further edges are counted.
- R7: Writing 0xA5 with data bit 0 equal to 0 clears the flag. Writing it with bit 0 equal to 1 leaves the flag unchanged.
- R8: If an overflow and a clear of the flag happen in the same cycle, the flag ends up set.
- R9: If a write to 0xA3 and a counted edge occur in the same cycle, the counter takes the written value and the edge is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| evt_i | input | 1 | Asynchronous event input |
| addr_i | input | 8 | Register address |
| wr_i | input | 1 | Write strobe, one cycle per access |
| rd_i | input | 1 | Read strobe, one cycle per access |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, registered on the read strobe |
| irq_o | output | 1 | Overflow interrupt request flag |

## Verification
An edge on evt_i reaches the counter on the third clock edge after it is driven. The bench therefore waits several cycles after each pulse before it reads the counter. Read data is registered, so the bench raises the strobe at a falling edge and samples rdata_o one falling edge later. A write takes effect on the clock edge that samples its strobe. For the same-cycle cases (R8, R9), the bench raises evt_i and then places the write strobe so that the clock edge sampling it is the third one after the input rose.

// File: rtl/evcnt_pkg.sv
package evcnt_pkg;
  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_LO,
    SEL_HI,
    SEL_CTL
  } reg_sel_e;
endpackage

// File: rtl/evcnt_edge.sv
module evcnt_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  output logic rise_o
);
  localparam int PIPE_W = SYNC_STAGES + 1;

  logic [PIPE_W-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[PIPE_W-2:0], evt_i};
  end

  // synchronized level vs its registered previous value
  assign rise_o = pipe_q[PIPE_W-2] & ~pipe_q[PIPE_W-1];
endmodule

// File: rtl/evcnt_core.sv
module evcnt_core #(
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  input  logic             load_en_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (load_en_i) cnt_q <= load_val_i;  // bus write wins
    else if (rise_i)    cnt_q <= cnt_q + 1'b1;
  end

  assign wrap_o = rise_i & ~load_en_i & (cnt_q == CNT_MAX);
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/evcnt_regif.sv
module evcnt_regif
  import evcnt_pkg::*;
#(
  parameter int              CNT_W    = 10,
  parameter int              BUS_W    = 8,
  parameter int              ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] ADDR_LO  = 8'hA3,
  parameter logic [ADDR_W-1:0] ADDR_HI  = 8'hA4,
  parameter logic [ADDR_W-1:0] ADDR_CTL = 8'hA5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [BUS_W-1:0]  wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              wrap_i,
  output logic              load_en_o,
  output logic [CNT_W-1:0]  load_val_o,
  output logic [BUS_W-1:0]  rdata_o,
  output logic              flag_o
);
  localparam int HI_W = CNT_W - BUS_W;

  reg_sel_e         sel;
  logic [HI_W-1:0]  hold_q, snap_q;
  logic [BUS_W-1:0] rdata_q;
  logic             flag_q, clr;

  always_comb begin
    if (addr_i == ADDR_LO)       sel = SEL_LO;
    else if (addr_i == ADDR_HI)  sel = SEL_HI;
    else if (addr_i == ADDR_CTL) sel = SEL_CTL;
    else                         sel = SEL_NONE;
  end

  assign load_en_o  = wr_i && (sel == SEL_LO);
  assign load_val_o = {hold_q, wdata_i};
  assign clr        = wr_i && (sel == SEL_CTL) && !wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hold_q <= '0;
    else if (wr_i && sel == SEL_HI) hold_q <= wdata_i[HI_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      snap_q  <= '0;
    end else if (rd_i) begin
      unique case (sel)
        SEL_LO: begin
          rdata_q <= cnt_i[BUS_W-1:0];
          snap_q  <= cnt_i[CNT_W-1:BUS_W];
        end
        SEL_HI:  rdata_q <= {{(BUS_W-HI_W){1'b0}}, snap_q};
        SEL_CTL: rdata_q <= {{(BUS_W-1){1'b0}}, flag_q};
        default: rdata_q <= '0;
      endcase
    end
  end

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (wrap_i) flag_q <= 1'b1;
    else if (clr)    flag_q <= 1'b0;
  end

  assign rdata_o = rdata_q;
  assign flag_o  = flag_q;
endmodule

// File: rtl/evcnt_top.sv
module evcnt_top #(
  parameter int                CNT_W       = 10,
  parameter int                BUS_W       = 8,
  parameter int                ADDR_W      = 8,
  parameter int                SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] ADDR_LO     = 8'hA3,
  parameter logic [ADDR_W-1:0] ADDR_HI     = 8'hA4,
  parameter logic [ADDR_W-1:0] ADDR_CTL    = 8'hA5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evt_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  output logic              irq_o
);
  logic             rise, load_en, wrap;
  logic [CNT_W-1:0] load_val, cnt_q;

  evcnt_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt_i), .rise_o(rise)
  );

  evcnt_core #(.CNT_W(CNT_W)) u_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .rise_i(rise), .load_en_i(load_en),
    .load_val_i(load_val), .cnt_o(cnt_q), .wrap_o(wrap)
  );

  evcnt_regif #(
    .CNT_W(CNT_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W),
    .ADDR_LO(ADDR_LO), .ADDR_HI(ADDR_HI), .ADDR_CTL(ADDR_CTL)
  ) u_regif (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_i(wr_i), .rd_i(rd_i),
    .wdata_i(wdata_i), .cnt_i(cnt_q), .wrap_i(wrap), .load_en_o(load_en),
    .load_val_o(load_val), .rdata_o(rdata_o), .flag_o(irq_o)
  );
endmodule

// File: rtl/evcnt_chk.sv
module evcnt_chk #(
  parameter int                CNT_W    = 10,
  parameter int                BUS_W    = 8,
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] ADDR_HI  = 8'hA4,
  parameter logic [ADDR_W-1:0] ADDR_CTL = 8'hA5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_i,
  input logic              rd_i,
  input logic [BUS_W-1:0]  wdata_i,
  input logic [BUS_W-1:0]  rdata_o,
  input logic              irq_o,
  input logic              rise,
  input logic              load_en,
  input logic [CNT_W-1:0]  cnt_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic clr_req;
  assign clr_req = wr_i && (addr_i == ADDR_CTL) && !wdata_i[0];

  a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise && !load_en |=> cnt_q == $past(cnt_q) + 1'b1);

  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rise && !load_en |=> $stable(cnt_q));

  a_r3_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_en |=> cnt_q[BUS_W-1:0] == $past(wdata_i));

  a_r5_hi_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && addr_i == ADDR_HI |=> rdata_o[BUS_W-1:2] == '0);

  a_r6_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise && !load_en && cnt_q == CNT_MAX |=> irq_o);

  a_r6_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !clr_req |=> irq_o);

  a_r7_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_req && !(rise && !load_en && cnt_q == CNT_MAX) |=> !irq_o);

  a_r8_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_req && rise && !load_en && cnt_q == CNT_MAX |=> irq_o);
endmodule

bind evcnt_top evcnt_chk #(
  .CNT_W(CNT_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W),
  .ADDR_HI(ADDR_HI), .ADDR_CTL(ADDR_CTL)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_i(wr_i), .rd_i(rd_i),
  .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o), .rise(rise),
  .load_en(load_en), .cnt_q(cnt_q)
);

// File: tb/sim_evcnt_top.sv
module sim_evcnt_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_LO = 8'hA3, A_HI = 8'hA4, A_CTL = 8'hA5;

  logic       clk_i = 1'b0, rst_ni = 1'b0, evt_i = 1'b0;
  logic [7:0] addr_i = '0, wdata_i = '0;
  logic       wr_i = 1'b0, rd_i = 1'b0;
  logic [7:0] rdata_o;
  logic       irq_o;
  int         checks = 0, failures = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  evcnt_top u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt_i), .addr_i(addr_i),
    .wr_i(wr_i), .rd_i(rd_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk_i); addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i); wr_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk_i); addr_i = a; rd_i = 1'b1;
    @(negedge clk_i); rd_i = 1'b0; d = rdata_o;
  endtask

  task automatic read_cnt(output int v);
    logic [7:0] lo, hi;
    bus_rd(A_LO, lo);
    bus_rd(A_HI, hi);
    v = {hi[1:0], lo};
  endtask

  task automatic set_cnt(input int v);
    bus_wr(A_HI, 8'(v >> 8));
    bus_wr(A_LO, 8'(v));
  endtask

  task automatic pulse(input int high_cycles);
    @(negedge clk_i); evt_i = 1'b1;
    repeat (high_cycles) @(negedge clk_i);
    evt_i = 1'b0;
    repeat (4) @(negedge clk_i);
  endtask

  // evt_i rises, then a write strobe lands on the third clock edge after it
  task automatic collide(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk_i); evt_i = 1'b1;
    @(posedge clk_i);
    @(posedge clk_i);
    @(negedge clk_i); addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i); wr_i = 1'b0;
    repeat (2) @(negedge clk_i); evt_i = 1'b0;
    repeat (4) @(negedge clk_i);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    check(irq_o == 1'b0, "R1 irq", irq_o, 0);
    bus_rd(A_LO, d);  check(d == 8'h00, "R1 low", d, 0);
    bus_rd(A_HI, d);  check(d == 8'h00, "R1 high", d, 0);
    bus_rd(A_CTL, d); check(d == 8'h00, "R1 status", d, 0);
  endtask

  task automatic t_count;
    int v;
    for (int i = 0; i < 5; i++) pulse(1);
    read_cnt(v); check(v == 5, "R2 five pulses", v, 5);
    pulse(20);
    read_cnt(v); check(v == 6, "R2 long level counts once", v, 6);
    repeat (10) @(negedge clk_i);
    read_cnt(v); check(v == 6, "R2 idle no count", v, 6);
  endtask

  task automatic t_write;
    int v;
    bus_wr(A_HI, 8'h02);
    read_cnt(v); check(v == 6, "R3 high write only latches", v, 6);
    bus_wr(A_LO, 8'h34);
    read_cnt(v); check(v == 'h234, "R3 low write commits", v, 'h234);
  endtask

  task automatic t_snapshot;
    logic [7:0] d;
    int v;
    set_cnt('h0FF);
    bus_rd(A_LO, d); check(d == 8'hFF, "R4 low read", d, 'hFF);
    pulse(1);
    bus_rd(A_HI, d); check(d == 8'h00, "R4 high from snapshot", d, 0);
    read_cnt(v); check(v == 'h100, "R4 fresh snapshot", v, 'h100);
  endtask

  task automatic t_unimpl;
    logic [7:0] d;
    set_cnt('hFFFF);
    bus_rd(A_LO, d); check(d == 8'hFF, "R5 low", d, 'hFF);
    bus_rd(A_HI, d); check(d == 8'h03, "R5 high upper bits zero", d, 3);
  endtask

  task automatic t_overflow;
    logic [7:0] d;
    int v;
    check(irq_o == 1'b0, "R6 no flag before wrap", irq_o, 0);
    pulse(1);
    read_cnt(v); check(v == 0, "R6 wrap to zero", v, 0);
    check(irq_o == 1'b1, "R6 irq set", irq_o, 1);
    bus_rd(A_CTL, d); check(d == 8'h01, "R6 status bit", d, 1);
    pulse(1);
    check(irq_o == 1'b1, "R6 sticky", irq_o, 1);
    bus_wr(A_CTL, 8'h01);
    check(irq_o == 1'b1, "R7 write one keeps flag", irq_o, 1);
    bus_wr(A_CTL, 8'h00);
    check(irq_o == 1'b0, "R7 write zero clears", irq_o, 0);
    bus_rd(A_CTL, d); check(d == 8'h00, "R7 status cleared", d, 0);
  endtask

  task automatic t_set_wins;
    set_cnt('h3FF);
    collide(A_CTL, 8'h00);
    check(irq_o == 1'b1, "R8 overflow beats clear", irq_o, 1);
    bus_wr(A_CTL, 8'h00);
    check(irq_o == 1'b0, "R8 later clear works", irq_o, 0);
  endtask

  task automatic t_write_wins;
    int v;
    set_cnt('h010);
    bus_wr(A_HI, 8'h00);
    collide(A_LO, 8'h55);
    read_cnt(v); check(v == 'h055, "R9 write beats edge", v, 'h055);
    set_cnt('h3FF);
    bus_wr(A_HI, 8'h01);
    collide(A_LO, 8'h20);
    read_cnt(v); check(v == 'h120, "R9 write at max", v, 'h120);
    check(irq_o == 1'b0, "R9 no overflow when write wins", irq_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_count();
    t_write();
    t_snapshot();
    t_unimpl();
    t_overflow();
    t_set_wins();
    t_write_wins();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule